// File: doc/BRIEF.md
# Program Exception and Trap Unit

This block sits beside the issue stage of a 32-bit RISC core and decides, for the instruction presented in the current cycle, whether it raises a program-class exception. Four causes are detected. A privileged operation issued in problem (user) state is one. A disabled quantized load/store or locked-cache zero operation is another. A trap compare whose enabled conditions hold is a third. The last is a floating-point enabled exception flagged by the execution side. Exactly one cause is recorded per exception.

On an exception the unit performs the entry update in the same cycle. The faulting address goes to the saved-PC register. The saved-status register receives the one-hot cause ORed with a masked copy of the machine state. The machine state has its little-endian bit reloaded from the interrupt-little-endian bit, and a fixed set of bits cleared. Fetch is redirected to the program exception vector. An instruction that does not fault commits: the fetch PC moves to the supplied next PC, and an MSR write takes effect.

Top module: `prog_exc_unit`

## Requirements
- R1: After reset, msr_o, srr0_o and srr1_o read 0 and pc_o reads the RESET_VEC parameter (default 0x00000100).
- R2: For op_i = 1 (trap), the five-bit trap_cond_i enables traps as follows: bit 4 on signed a<b, bit 3 on signed a>b, bit 2 on a==b, bit 1 on unsigned a<b, bit 0 on unsigned a>b. A trap is raised when any enabled relation holds. The trap cause is srr1 bit value 1<<17.
- R3: When MSR bit 14 (problem state) is set, the following ops raise the privileged cause (1<<18) and do not execute: 2 read MSR, 3 write MSR, 4 segment move, 5 cache invalidate, 6 TLB invalidate, 7 TLB sync, 8 return-from-interrupt. With bit 14 clear they commit.
- R4: In problem state, op 9 (SPR read) is allowed only for SPR indices 1, 8, 9, 268 and 269. Op 10 (SPR write) is allowed only for indices 1, 8 and 9. Any other index raises the privileged cause.
- R5: Op 11 (quantized load/store) with quant_en_i low, and op 12 (locked-cache zero) with lczero_en_i low, raise the illegal cause (1<<19).
- R6: fp_exc_i high on a valid instruction raises the floating-point cause (1<<20).
- R7: When several causes apply at once, exactly one is recorded. The priority is privileged, then illegal, then trap, then floating-point.
- R8: On entry, srr1_o becomes the cause bit ORed with (previous MSR AND 0x87C0FFFF). No cause bit survives from an earlier exception.
- R9: On entry, srr0_o becomes the pc_o of the faulting instruction, and pc_o becomes EXC_VEC (default 0x00000700).
- R10: On entry, MSR bit 0 takes the old bit 16, and then bits 0x0004EF36 are cleared.
- R11: A faulting instruction has no side effects: commit_o stays low, and an MSR write (op 3) is discarded. A non-faulting op 3 loads msr_wdata_i into the MSR.
- R12: exc_o is asserted in the same cycle as the instruction, and the registers change at that clock edge. A committed instruction sets pc_o to next_pc_i. With valid_i low, all registers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction presented this cycle |
| op_i | input | 4 | Operation class code (see R2 to R5, R11) |
| next_pc_i | input | 32 | PC to take when the instruction commits |
| trap_a_i | input | 32 | First trap operand |
| trap_b_i | input | 32 | Second trap operand |
| trap_cond_i | input | 5 | Trap condition enables |
| spr_idx_i | input | 10 | SPR index for ops 9 and 10 |
| msr_wdata_i | input | 32 | New MSR value for op 3 |
| quant_en_i | input | 1 | Quantized load/store enable |
| lczero_en_i | input | 1 | Locked-cache zero enable |
| fp_exc_i | input | 1 | Floating-point enabled exception flag |
| commit_o | output | 1 | Instruction executes without exception |
| exc_o | output | 1 | Program exception taken this cycle |
| pc_o | output | 32 | Current fetch PC |
| msr_o | output | 32 | Machine state register |
| srr0_o | output | 32 | Saved PC |
| srr1_o | output | 32 | Saved status with cause bit |

## Verification
The functions that can coincide are the cause detectors. A floating-point flag can arrive in the same cycle as a firing trap, as a privileged op in user state, or as a disabled quantized op. A disabled quantized op can also arrive in user state. The bench raises these pairs together in single cycles and checks that srr1 carries only the higher-priority cause, with the masked MSR copy beside it. It also checks that the MSR is cleared and the vector is taken exactly as for a single cause.

// File: rtl/prog_exc_pkg.sv
package prog_exc_pkg;
  localparam int XLEN = 32;
  localparam int SPR_W = 10;

  typedef enum logic [3:0] {
    OP_NONE    = 4'd0,
    OP_TRAP    = 4'd1,
    OP_MFMSR   = 4'd2,
    OP_MTMSR   = 4'd3,
    OP_SEGMOV  = 4'd4,
    OP_DCINV   = 4'd5,
    OP_TLBINV  = 4'd6,
    OP_TLBSYNC = 4'd7,
    OP_RFI     = 4'd8,
    OP_SPR_RD  = 4'd9,
    OP_SPR_WR  = 4'd10,
    OP_QUANT   = 4'd11,
    OP_LCZERO  = 4'd12
  } op_e;

  localparam int CAUSE_FP_BIT   = 20;
  localparam int CAUSE_ILL_BIT  = 19;
  localparam int CAUSE_PRIV_BIT = 18;
  localparam int CAUSE_TRAP_BIT = 17;

  localparam int MSR_PR_BIT  = 14;
  localparam int MSR_LE_BIT  = 0;
  localparam int MSR_ILE_BIT = 16;

  localparam logic [XLEN-1:0] SAVE_MASK  = 32'h87C0_FFFF;
  localparam logic [XLEN-1:0] CLEAR_MASK = 32'h0004_EF36;

  localparam logic [SPR_W-1:0] SPR_XER = 10'd1;
  localparam logic [SPR_W-1:0] SPR_LR  = 10'd8;
  localparam logic [SPR_W-1:0] SPR_CTR = 10'd9;
  localparam logic [SPR_W-1:0] SPR_TBL = 10'd268;
  localparam logic [SPR_W-1:0] SPR_TBU = 10'd269;

  typedef struct packed {
    logic priv;
    logic ill;
    logic trap;
    logic fp;
  } cause_t;
endpackage

// File: rtl/prog_exc_trap_cmp.sv
module prog_exc_trap_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [4:0]   cond_i,
  output logic         hit_o
);
  logic [4:0] rel;

  always_comb begin
    rel[4] = $signed(a_i) < $signed(b_i);
    rel[3] = $signed(a_i) > $signed(b_i);
    rel[2] = a_i == b_i;
    rel[1] = a_i < b_i;
    rel[0] = a_i > b_i;
  end

  assign hit_o = |(rel & cond_i);
endmodule

// File: rtl/prog_exc_detect.sv
module prog_exc_detect
  import prog_exc_pkg::*;
(
  input  logic             valid_i,
  input  op_e              op_i,
  input  logic             pr_i,
  input  logic [SPR_W-1:0] spr_idx_i,
  input  logic             quant_en_i,
  input  logic             lczero_en_i,
  input  logic             trap_hit_i,
  input  logic             fp_exc_i,
  output cause_t           cause_o,
  output logic             exc_o
);
  logic priv_op, rd_ok, wr_ok;
  cause_t raw;

  always_comb begin
    priv_op = op_i inside {OP_MFMSR, OP_MTMSR, OP_SEGMOV, OP_DCINV,
                           OP_TLBINV, OP_TLBSYNC, OP_RFI};
    wr_ok   = spr_idx_i inside {SPR_XER, SPR_LR, SPR_CTR};
    rd_ok   = wr_ok || spr_idx_i inside {SPR_TBL, SPR_TBU};

    raw.priv = pr_i && (priv_op || (op_i == OP_SPR_RD && !rd_ok)
                                || (op_i == OP_SPR_WR && !wr_ok));
    raw.ill  = (op_i == OP_QUANT && !quant_en_i) || (op_i == OP_LCZERO && !lczero_en_i);
    raw.trap = (op_i == OP_TRAP) && trap_hit_i;
    raw.fp   = fp_exc_i;

    // keep only the highest-priority cause
    cause_o = '0;
    if (valid_i) begin
      if      (raw.priv) cause_o.priv = 1'b1;
      else if (raw.ill)  cause_o.ill  = 1'b1;
      else if (raw.trap) cause_o.trap = 1'b1;
      else if (raw.fp)   cause_o.fp   = 1'b1;
    end
    exc_o = |cause_o;
  end
endmodule

// File: rtl/prog_exc_state.sv
module prog_exc_state
  import prog_exc_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_0100,
  parameter logic [XLEN-1:0] EXC_VEC   = 32'h0000_0700
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            exc_i,
  input  cause_t          cause_i,
  input  logic            msr_wr_i,
  input  logic [XLEN-1:0] msr_wdata_i,
  input  logic [XLEN-1:0] next_pc_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] msr_o,
  output logic [XLEN-1:0] srr0_o,
  output logic [XLEN-1:0] srr1_o
);
  logic [XLEN-1:0] cause_word, msr_le, msr_entry;

  always_comb begin
    cause_word = '0;
    cause_word[CAUSE_PRIV_BIT] = cause_i.priv;
    cause_word[CAUSE_ILL_BIT]  = cause_i.ill;
    cause_word[CAUSE_TRAP_BIT] = cause_i.trap;
    cause_word[CAUSE_FP_BIT]   = cause_i.fp;
    msr_le = msr_o;
    msr_le[MSR_LE_BIT] = msr_o[MSR_ILE_BIT];
    msr_entry = msr_le & ~CLEAR_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o   <= RESET_VEC;
      msr_o  <= '0;
      srr0_o <= '0;
      srr1_o <= '0;
    end else if (exc_i) begin
      srr0_o <= pc_o;
      srr1_o <= cause_word | (msr_o & SAVE_MASK);
      msr_o  <= msr_entry;
      pc_o   <= EXC_VEC;
    end else if (valid_i) begin
      pc_o <= next_pc_i;
      if (msr_wr_i) msr_o <= msr_wdata_i;
    end
  end
endmodule

// File: rtl/prog_exc_unit.sv
module prog_exc_unit
  import prog_exc_pkg::*;
#(
  parameter logic [31:0] RESET_VEC = 32'h0000_0100,
  parameter logic [31:0] EXC_VEC   = 32'h0000_0700
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [3:0]  op_i,
  input  logic [31:0] next_pc_i,
  input  logic [31:0] trap_a_i,
  input  logic [31:0] trap_b_i,
  input  logic [4:0]  trap_cond_i,
  input  logic [9:0]  spr_idx_i,
  input  logic [31:0] msr_wdata_i,
  input  logic        quant_en_i,
  input  logic        lczero_en_i,
  input  logic        fp_exc_i,
  output logic        commit_o,
  output logic        exc_o,
  output logic [31:0] pc_o,
  output logic [31:0] msr_o,
  output logic [31:0] srr0_o,
  output logic [31:0] srr1_o
);
  op_e    op;
  logic   trap_hit;
  cause_t cause;

  assign op = op_e'(op_i);

  prog_exc_trap_cmp #(.W(XLEN)) u_cmp (
    .a_i    (trap_a_i),
    .b_i    (trap_b_i),
    .cond_i (trap_cond_i),
    .hit_o  (trap_hit)
  );

  prog_exc_detect u_det (
    .valid_i     (valid_i),
    .op_i        (op),
    .pr_i        (msr_o[MSR_PR_BIT]),
    .spr_idx_i   (spr_idx_i),
    .quant_en_i  (quant_en_i),
    .lczero_en_i (lczero_en_i),
    .trap_hit_i  (trap_hit),
    .fp_exc_i    (fp_exc_i),
    .cause_o     (cause),
    .exc_o       (exc_o)
  );

  assign commit_o = valid_i && !exc_o;

  prog_exc_state #(.RESET_VEC(RESET_VEC), .EXC_VEC(EXC_VEC)) u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (valid_i),
    .exc_i       (exc_o),
    .cause_i     (cause),
    .msr_wr_i    (commit_o && op == OP_MTMSR),
    .msr_wdata_i (msr_wdata_i),
    .next_pc_i   (next_pc_i),
    .pc_o        (pc_o),
    .msr_o       (msr_o),
    .srr0_o      (srr0_o),
    .srr1_o      (srr1_o)
  );
endmodule

// File: rtl/prog_exc_chk.sv
module prog_exc_chk
  import prog_exc_pkg::*;
#(
  parameter logic [31:0] EXC_VEC = 32'h0000_0700
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [3:0]  op_i,
  input logic        commit_o,
  input logic        exc_o,
  input logic [31:0] pc_o,
  input logic [31:0] msr_o,
  input logic [31:0] srr0_o,
  input logic [31:0] srr1_o
);
  a_r9_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |=> pc_o == EXC_VEC);

  a_r9_saved_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |=> srr0_o == $past(pc_o));

  a_r10_msr_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |=> ((msr_o & CLEAR_MASK) == '0) && (msr_o[MSR_LE_BIT] == $past(msr_o[MSR_ILE_BIT])));

  a_r8_saved_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |=> (srr1_o & SAVE_MASK) == ($past(msr_o) & SAVE_MASK));

  a_r7_one_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |=> $countones(srr1_o[CAUSE_FP_BIT:CAUSE_TRAP_BIT]) == 1);

  a_r11_no_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> !commit_o);

  a_r3_user_msr_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && msr_o[MSR_PR_BIT] && op_i == OP_MTMSR) |-> exc_o);

  a_r12_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(pc_o) && $stable(msr_o) && $stable(srr0_o) && $stable(srr1_o));
endmodule

bind prog_exc_unit prog_exc_chk #(.EXC_VEC(EXC_VEC)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .commit_o (commit_o),
  .exc_o    (exc_o),
  .pc_o     (pc_o),
  .msr_o    (msr_o),
  .srr0_o   (srr0_o),
  .srr1_o   (srr1_o)
);

// File: tb/tb_prog_exc_unit.sv
module tb_prog_exc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        v = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] npc = '0, ta = '0, tb = '0, wd = '0;
  logic [4:0]  tc = '0;
  logic [9:0]  si = '0;
  logic        qen = 1'b0, lzen = 1'b0, fp = 1'b0;
  logic        commit, exc;
  logic [31:0] pc, msr, srr0, srr1;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  prog_exc_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(v), .op_i(op), .next_pc_i(npc),
    .trap_a_i(ta), .trap_b_i(tb), .trap_cond_i(tc), .spr_idx_i(si),
    .msr_wdata_i(wd), .quant_en_i(qen), .lczero_en_i(lzen), .fp_exc_i(fp),
    .commit_o(commit), .exc_o(exc), .pc_o(pc), .msr_o(msr),
    .srr0_o(srr0), .srr1_o(srr1)
  );

  typedef struct {
    logic [31:0] pc, msr, srr0, srr1;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  logic [31:0] m_pc = 32'h100, m_msr = '0, m_srr0 = '0, m_srr1 = '0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, expv);
    end
  endtask

  // reference cause word from the requirements
  function automatic logic [31:0] exp_cause();
    logic user, priv, ill, trp;
    user = m_msr[14];
    priv = 1'b0;
    if (user) begin
      if (op >= 4'd2 && op <= 4'd8) priv = 1'b1;
      if (op == 4'd9 && !(si == 1 || si == 8 || si == 9 || si == 268 || si == 269)) priv = 1'b1;
      if (op == 4'd10 && !(si == 1 || si == 8 || si == 9)) priv = 1'b1;
    end
    ill = (op == 4'd11 && !qen) || (op == 4'd12 && !lzen);
    trp = (op == 4'd1) &&
          ((tc[4] && $signed(ta) < $signed(tb)) || (tc[3] && $signed(ta) > $signed(tb)) ||
           (tc[2] && ta == tb) || (tc[1] && ta < tb) || (tc[0] && ta > tb));
    if (priv) return 32'h0004_0000;
    if (ill)  return 32'h0008_0000;
    if (trp)  return 32'h0002_0000;
    if (fp)   return 32'h0010_0000;
    return '0;
  endfunction

  // driver: called at a falling edge, applies one instruction and queues the expected state
  task automatic issue(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] c, input logic [9:0] s, input logic [31:0] w,
                       input logic f, input string tag);
    logic [31:0] cw;
    exp_t e;
    v = 1'b1; op = o; ta = a; tb = b; tc = c; si = s; wd = w; fp = f;
    npc = m_pc + 32'd4;
    #1;
    cw = exp_cause();
    check({tag, " exc"}, {31'd0, exc}, {31'd0, cw != 0});
    check({tag, " R11 commit"}, {31'd0, commit}, {31'd0, cw == 0});
    if (cw != 0) begin
      m_srr0 = m_pc;
      m_srr1 = cw | (m_msr & 32'h87C0_FFFF);
      m_msr[0] = m_msr[16];
      m_msr = m_msr & ~32'h0004_EF36;
      m_pc = 32'h700;
    end else begin
      if (o == 4'd3) m_msr = w;
      m_pc = npc;
    end
    e.pc = m_pc; e.msr = m_msr; e.srr0 = m_srr0; e.srr1 = m_srr1; e.tag = tag;
    sbq.push_back(e);
    @(negedge clk);
    v = 1'b0; fp = 1'b0; op = '0;
  endtask

  task automatic idle(input string tag);
    exp_t e;
    v = 1'b0;
    #1;
    e.pc = m_pc; e.msr = m_msr; e.srr0 = m_srr0; e.srr1 = m_srr1; e.tag = tag;
    sbq.push_back(e);
    @(negedge clk);
  endtask

  // enter user state: supervisor MSR write with PR, ILE, LE, EE and IR/DR set
  task automatic go_user();
    issue(4'd3, 0, 0, 0, 0, 32'h0001_C031, 1'b0, "R11 mtmsr supervisor");
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      check({e.tag, " pc R9/R12"}, pc, e.pc);
      check({e.tag, " msr R10/R11"}, msr, e.msr);
      check({e.tag, " srr0 R9"}, srr0, e.srr0);
      check({e.tag, " srr1 R8"}, srr1, e.srr1);
    end
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #23;
    check("R1 pc", pc, 32'h100);
    check("R1 msr", msr, 32'h0);
    check("R1 srr0", srr0, 32'h0);
    check("R1 srr1", srr1, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    idle("R12 idle");
    // R2 trap predicate, supervisor state
    issue(4'd1, 32'hFFFF_FFFF, 32'd1, 5'h10, 0, 0, 1'b0, "R2 signed lt");
    issue(4'd1, 32'hFFFF_FFFF, 32'd1, 5'h08, 0, 0, 1'b0, "R2 signed gt none");
    issue(4'd1, 32'hFFFF_FFFF, 32'd1, 5'h02, 0, 0, 1'b0, "R2 unsigned lt none");
    issue(4'd1, 32'hFFFF_FFFF, 32'd1, 5'h01, 0, 0, 1'b0, "R2 unsigned gt");
    issue(4'd1, 32'd1, 32'hFFFF_FFFF, 5'h08, 0, 0, 1'b0, "R2 signed gt");
    issue(4'd1, 32'd1, 32'hFFFF_FFFF, 5'h02, 0, 0, 1'b0, "R2 unsigned lt");
    issue(4'd1, 32'd7, 32'd7, 5'h04, 0, 0, 1'b0, "R2 equal");
    issue(4'd1, 32'd7, 32'd7, 5'h1B, 0, 0, 1'b0, "R2 equal masked");
    idle("R12 idle after trap");

    // R3 privileged ops
    issue(4'd5, 0, 0, 0, 0, 0, 1'b0, "R3 cache inv supervisor");
    go_user();
    issue(4'd3, 0, 0, 0, 0, 32'hFFFF_FFFF, 1'b0, "R3 R11 user mtmsr");
    go_user();
    issue(4'd8, 0, 0, 0, 0, 0, 1'b0, "R3 user rfi");
    go_user();
    issue(4'd7, 0, 0, 0, 0, 0, 1'b0, "R3 user tlbsync");

    // R4 SPR access in user state
    go_user();
    issue(4'd9, 0, 0, 0, 10'd268, 0, 1'b0, "R4 user read time base");
    issue(4'd10, 0, 0, 0, 10'd9, 0, 1'b0, "R4 user write ctr");
    issue(4'd10, 0, 0, 0, 10'd268, 0, 1'b0, "R4 user write time base");
    go_user();
    issue(4'd9, 0, 0, 0, 10'd272, 0, 1'b0, "R4 user read other");

    // R5 illegal ops
    qen = 1'b1; lzen = 1'b1;
    issue(4'd11, 0, 0, 0, 0, 0, 1'b0, "R5 quant enabled");
    issue(4'd12, 0, 0, 0, 0, 0, 1'b0, "R5 lczero enabled");
    qen = 1'b0;
    issue(4'd11, 0, 0, 0, 0, 0, 1'b0, "R5 quant disabled");
    lzen = 1'b0;
    issue(4'd12, 0, 0, 0, 0, 0, 1'b0, "R5 lczero disabled");

    // R6 floating point and R7 priority
    issue(4'd0, 0, 0, 0, 0, 0, 1'b1, "R6 fp alone");
    issue(4'd1, 32'd3, 32'd3, 5'h04, 0, 0, 1'b1, "R7 trap over fp");
    issue(4'd5, 0, 0, 0, 0, 0, 1'b1, "R7 fp supervisor cache inv");
    go_user();
    issue(4'd6, 0, 0, 0, 0, 0, 1'b1, "R7 priv over fp");
    go_user();
    issue(4'd11, 0, 0, 0, 0, 0, 1'b1, "R7 illegal over fp");
    go_user();
    issue(4'd10, 0, 0, 0, 10'd300, 0, 1'b1, "R7 priv spr over fp");
    idle("R12 final idle");
    @(negedge clk);
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule